// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block collects up to thirteen level-sensitive interrupt requests, numbered 1 to 13, and presents one CPU interrupt level together with the vector number the processor should use. Each source has an 8-bit control byte. The control byte sets the source's interrupt level, a priority within that level, and whether the vector is derived from the level or read from a dedicated vector register. A mask register blocks individual sources. A read-only pending view shows the raw requests.

Software programs the block through a simple single-cycle register port with a write strobe, a byte address and 16-bit data. Reads are combinational from the address. The level and vector outputs are registered. They follow any change of requests, mask or control bytes one clock later. The acknowledge cycle is handled elsewhere.

Top module: `irq_vec_arbiter`

## Requirements
- R1: Pending bit n (1..13) equals request input n at all times. Reading offset 0x3A returns the requests in bits 13:1, with bit 0 and bits 15:14 at zero. Writing offset 0x3A changes no register and no output.
- R2: Source n is active only when its pending bit is 1 and mask bit n is 0. The mask is at offset 0x36, is 16 bits wide and resets to 0x3FFE. When no source is active, both outputs are 0.
- R3: Among active sources, the winner has the largest value in control bits 4:0. On equal values, the lowest source number wins.
- R4: When the winning value is below 4, the level output and the vector output are both 0.
- R5: Otherwise the level output equals bits 4:2 of the winner's control byte.
- R6: When bit 7 of the winner's control byte is 1, the vector is 24 plus the level.
- R7: When bit 7 is 0, the vector comes from a fixed place depending on the winning source: source 8 uses the watchdog vector register (offset 0x42), source 12 the first serial vector register (0x44), source 13 the second serial vector register (0x45), and any other source uses 0x0F. All three vector registers reset to 0x0F and take data bits 7:0 on a write.
- R8: After reset, the control bytes of sources 1..8 are 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C. Sources 9..11 reset to 0x80, and sources 12 and 13 reset to 0x00.
- R9: The control byte of source n sits at offset 0x13+n. A write stores data bits 7:0, and a read returns the byte zero-extended to 16 bits.
- R10: Level and vector are registered. They are 0 in reset and take a new value at the first rising edge after a request change. After a register write, they take the new value at the following edge.
- R11: Offsets with no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wr_data | input | 16 | Write data |
| reg_rd_data | output | 16 | Read data for reg_addr |
| irq_req | input | 13 | Level-sensitive requests, bit n-1 is source n |
| cpu_level | output | 3 | Presented interrupt level, 0 for none |
| cpu_vector | output | 8 | Vector number, 0 when level is 0 |

## Verification
Two functions can fall in the same cycle: a register write that reprograms a control byte or the mask, and a change on the request lines. Both feed the registered outputs. The bench provokes this by changing the mask and control bytes between full sweeps of all 8192 request patterns. It also writes the read-only pending offset while requests are held. After each step, the outputs are compared one edge later against an arithmetic model kept in the bench. The model is built only from the values the bench itself wrote.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int IRQC_NUM_SRC = 13;
    localparam int IRQC_AW      = 8;
    localparam int IRQC_DW      = 16;

    typedef struct packed {
        logic [2:0] level;
        logic [7:0] vector;
    } irq_out_t;

    // Power-up control byte for source n
    function automatic logic [7:0] ctrl_reset_val(input int n);
        logic [7:0] v;
        if (n >= 1 && n <= 7)       v = 8'(n * 4);
        else if (n == 8)            v = 8'h1C;
        else if (n >= 9 && n <= 11) v = 8'h80;
        else                        v = 8'h00;
        return v;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int          NUM_SRC   = IRQC_NUM_SRC,
    parameter int          AW        = IRQC_AW,
    parameter int          DW        = IRQC_DW,
    parameter int          CTRL_BASE = 'h13,
    parameter int          MASK_ADDR = 'h36,
    parameter int          PEND_ADDR = 'h3A,
    parameter int          WDV_ADDR  = 'h42,
    parameter int          U0V_ADDR  = 'h44,
    parameter int          U1V_ADDR  = 'h45,
    parameter logic [15:0] MASK_RST  = 16'h3FFE,
    parameter logic [7:0]  VEC_RST   = 8'h0F
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wr_data,
    output logic [DW-1:0]           rd_data,
    input  logic [NUM_SRC:1]        pend,
    output logic [NUM_SRC:0][7:0]   ctrl,
    output logic [DW-1:0]           mask,
    output logic [7:0]              wdv,
    output logic [7:0]              u0v,
    output logic [7:0]              u1v
);

    typedef struct packed {
        logic [NUM_SRC:0][7:0] ctrl;
        logic [DW-1:0]         mask;
        logic [7:0]            wdv;
        logic [7:0]            u0v;
        logic [7:0]            u1v;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int n = 1; n <= NUM_SRC; n++) begin
                if (addr == AW'(CTRL_BASE + n)) st_d.ctrl[n] = wr_data[7:0];
            end
            if (addr == AW'(MASK_ADDR)) st_d.mask = wr_data;
            if (addr == AW'(WDV_ADDR))  st_d.wdv  = wr_data[7:0];
            if (addr == AW'(U0V_ADDR))  st_d.u0v  = wr_data[7:0];
            if (addr == AW'(U1V_ADDR))  st_d.u1v  = wr_data[7:0];
        end
        st_d.ctrl[0] = 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n <= NUM_SRC; n++) st_q.ctrl[n] <= ctrl_reset_val(n);
            st_q.mask <= DW'(MASK_RST);
            st_q.wdv  <= VEC_RST;
            st_q.u0v  <= VEC_RST;
            st_q.u1v  <= VEC_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (addr == AW'(CTRL_BASE + n)) rd_data[7:0] = st_q.ctrl[n];
        end
        if (addr == AW'(MASK_ADDR)) rd_data = st_q.mask;
        if (addr == AW'(PEND_ADDR)) rd_data[NUM_SRC:0] = {pend, 1'b0};
        if (addr == AW'(WDV_ADDR))  rd_data[7:0] = st_q.wdv;
        if (addr == AW'(U0V_ADDR))  rd_data[7:0] = st_q.u0v;
        if (addr == AW'(U1V_ADDR))  rd_data[7:0] = st_q.u1v;
    end

    assign ctrl = st_q.ctrl;
    assign mask = st_q.mask;
    assign wdv  = st_q.wdv;
    assign u0v  = st_q.u0v;
    assign u1v  = st_q.u1v;

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = IRQC_NUM_SRC,
    localparam int IW     = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC:1]      pend,
    input  logic [NUM_SRC:1]      mask_bits,
    input  logic [NUM_SRC:0][7:0] ctrl,
    output logic [IW-1:0]         win_idx,
    output logic [4:0]            win_code
);

    logic [NUM_SRC:1] active;

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_act
        assign active[g] = pend[g] & ~mask_bits[g];
    end

    // Ascending scan; only a strictly larger code displaces the holder
    always_comb begin
        win_idx  = '0;
        win_code = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (active[i] && (ctrl[i][4:0] > win_code)) begin
                win_code = ctrl[i][4:0];
                win_idx  = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_vecgen.sv
module irqc_vecgen
    import irqc_pkg::*;
#(
    parameter int         NUM_SRC   = IRQC_NUM_SRC,
    parameter int         WDOG_SRC  = 8,
    parameter int         U0_SRC    = 12,
    parameter int         U1_SRC    = 13,
    parameter int         AUTO_BASE = 24,
    parameter int         MIN_CODE  = 4,
    parameter logic [7:0] DFLT_VEC  = 8'h0F,
    localparam int        IW        = $clog2(NUM_SRC + 1)
) (
    input  logic [IW-1:0]         win_idx,
    input  logic [4:0]            win_code,
    input  logic [NUM_SRC:0][7:0] ctrl,
    input  logic [7:0]            wdv,
    input  logic [7:0]            u0v,
    input  logic [7:0]            u1v,
    output irq_out_t              out
);

    logic [7:0] sel;

    always_comb begin
        sel = ctrl[win_idx];
        out = '0;
        if (win_code >= 5'(MIN_CODE)) begin
            out.level = sel[4:2];
            if (sel[7]) begin
                out.vector = 8'(AUTO_BASE) + {5'b0, sel[4:2]};
            end else if (win_idx == IW'(WDOG_SRC)) begin
                out.vector = wdv;
            end else if (win_idx == IW'(U0_SRC)) begin
                out.vector = u0v;
            end else if (win_idx == IW'(U1_SRC)) begin
                out.vector = u1v;
            end else begin
                out.vector = DFLT_VEC;
            end
        end
    end

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = IRQC_NUM_SRC,
    parameter int AW      = IRQC_AW,
    parameter int DW      = IRQC_DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [AW-1:0]      reg_addr,
    input  logic [DW-1:0]      reg_wr_data,
    output logic [DW-1:0]      reg_rd_data,
    input  logic [NUM_SRC:1]   irq_req,
    output logic [2:0]         cpu_level,
    output logic [7:0]         cpu_vector
);

    localparam int IW = $clog2(NUM_SRC + 1);

    logic [NUM_SRC:0][7:0] ctrl_w;
    logic [DW-1:0]         mask_w;
    logic [7:0]            wdv_w, u0v_w, u1v_w;
    logic [IW-1:0]         win_idx_w;
    logic [4:0]            win_code_w;
    irq_out_t              next_w;
    irq_out_t              out_d, out_q;

    irqc_regs #(.NUM_SRC(NUM_SRC), .AW(AW), .DW(DW)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wr_data (reg_wr_data),
        .rd_data (reg_rd_data),
        .pend    (irq_req),
        .ctrl    (ctrl_w),
        .mask    (mask_w),
        .wdv     (wdv_w),
        .u0v     (u0v_w),
        .u1v     (u1v_w)
    );

    irqc_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
        .pend      (irq_req),
        .mask_bits (mask_w[NUM_SRC:1]),
        .ctrl      (ctrl_w),
        .win_idx   (win_idx_w),
        .win_code  (win_code_w)
    );

    irqc_vecgen #(.NUM_SRC(NUM_SRC)) vec_i (
        .win_idx  (win_idx_w),
        .win_code (win_code_w),
        .ctrl     (ctrl_w),
        .wdv      (wdv_w),
        .u0v      (u0v_w),
        .u1v      (u1v_w),
        .out      (next_w)
    );

    always_comb begin
        out_d = next_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cpu_level  = out_q.level;
    assign cpu_vector = out_q.vector;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_SRC   = 13,
    parameter int AW        = 8,
    parameter int PEND_ADDR = 'h3A
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_SRC:1]  irq_req,
    input logic [NUM_SRC:1]  mask_bits,
    input logic              reg_wr_en,
    input logic [AW-1:0]     reg_addr,
    input logic [2:0]        cpu_level,
    input logic [7:0]        cpu_vector
);

    AST_IDLE_WHEN_NONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & ~mask_bits) == '0) |=> (cpu_level == 3'd0 && cpu_vector == 8'd0)); // R2

    AST_ZERO_LEVEL_ZERO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level == 3'd0) |-> (cpu_vector == 8'd0)); // R4

    AST_LEVEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level != 3'd0) |-> $past(|irq_req)); // R10

    AST_PEND_WRITE_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == AW'(PEND_ADDR)) |=> $stable(mask_bits)); // R1

endmodule

bind irq_vec_arbiter irqc_checker #(.NUM_SRC(NUM_SRC), .AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .mask_bits  (mask_w[NUM_SRC:1]),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .cpu_level  (cpu_level),
    .cpu_vector (cpu_vector)
);

// File: tb/irq_vec_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_vec_arbiter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wr_data = '0;
    logic [15:0] reg_rd_data;
    logic [13:1] irq_req = '0;
    logic [2:0]  cpu_level;
    logic [7:0]  cpu_vector;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0]  m_ctrl [1:13];
    logic [15:0] m_mask;
    logic [7:0]  m_wdv, m_u0v, m_u1v;

    always #2.5 clk = ~clk;

    irq_vec_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .irq_req(irq_req),
        .cpu_level(cpu_level), .cpu_vector(cpu_vector)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a >= 8'h14 && a <= 8'h20) m_ctrl[a - 8'h13] = d[7:0];
        if (a == 8'h36) m_mask = d;
        if (a == 8'h42) m_wdv = d[7:0];
        if (a == 8'h44) m_u0v = d[7:0];
        if (a == 8'h45) m_u1v = d[7:0];
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rd_data;
    endtask

    // Expected {level, vector} from the requirements
    function automatic logic [10:0] model(input logic [13:1] r);
        int best = 0, idx = 0;
        logic [2:0] lv;
        logic [7:0] vc;
        for (int i = 1; i <= 13; i++)
            if (r[i] && !m_mask[i] && int'(m_ctrl[i][4:0]) > best) begin
                best = int'(m_ctrl[i][4:0]); idx = i;
            end
        if (best < 4) return '0;
        lv = m_ctrl[idx][4:2];
        if (m_ctrl[idx][7]) vc = 8'(24 + int'(lv));
        else if (idx == 8)  vc = m_wdv;
        else if (idx == 12) vc = m_u0v;
        else if (idx == 13) vc = m_u1v;
        else                vc = 8'h0F;
        return {lv, vc};
    endfunction

    task automatic run_case(input logic [13:1] v, input string tag);
        logic [10:0] e;
        @(negedge clk);
        irq_req = v;
        @(negedge clk);
        e = model(v);
        chk(tag, int'(cpu_level), int'(e[10:8]));
        chk(tag, int'(cpu_vector), int'(e[7:0]));
    endtask

    task automatic sweep(input string tag);
        for (int v = 0; v < 8192; v++) run_case(13'(v), tag);
    endtask

    initial begin
        logic [15:0] d;
        for (int i = 1; i <= 13; i++)
            m_ctrl[i] = (i <= 7) ? 8'(4 * i) : (i == 8) ? 8'h1C : (i <= 11) ? 8'h80 : 8'h00;
        m_mask = 16'h3FFE; m_wdv = 8'h0F; m_u0v = 8'h0F; m_u1v = 8'h0F;

        repeat (3) @(negedge clk);
        chk("R10 reset level", int'(cpu_level), 0);
        chk("R10 reset vector", int'(cpu_vector), 0);
        rst_n = 1'b1;

        for (int i = 1; i <= 13; i++) begin
            rd(8'(8'h13 + i), d);
            chk("R8 reset ctrl", int'(d), int'(m_ctrl[i]));
        end
        rd(8'h36, d); chk("R2 reset mask", int'(d), 'h3FFE);
        rd(8'h42, d); chk("R7 reset wdog vector", int'(d), 'h0F);
        rd(8'h44, d); chk("R7 reset serial0 vector", int'(d), 'h0F);
        rd(8'h45, d); chk("R7 reset serial1 vector", int'(d), 'h0F);
        rd(8'h50, d); chk("R11 unmapped read", int'(d), 0);
        rd(8'h13, d); chk("R11 offset below ctrl", int'(d), 0);

        // R1 pending view and read-only behaviour
        @(negedge clk); irq_req = 13'h1A5B;
        rd(8'h3A, d); chk("R1 pending read", int'(d), 'h34B6);
        wr(8'h3A, 16'h0000);
        rd(8'h36, d); chk("R1 pending write keeps mask", int'(d), 'h3FFE);
        rd(8'h3A, d); chk("R1 pending write keeps pending", int'(d), 'h34B6);
        chk("R2 all masked level", int'(cpu_level), 0);

        // Reset config, everything unmasked
        wr(8'h36, 16'h0000);
        sweep("R3 R5 R7 reset-config sweep");

        // R10 timing: output moves only at the next edge
        run_case(13'h0, "R10 idle");
        @(negedge clk); irq_req = 13'h0040;
        #1 chk("R10 before edge", int'(cpu_level), 0);
        @(negedge clk);
        chk("R10 after edge level", int'(cpu_level), 7);
        chk("R10 after edge vector", int'(cpu_vector), 'h0F);

        // R3 tie: sources 7 and 8 share code 0x1C
        wr(8'h42, 16'h0040);
        run_case(13'h00C0, "R3 tie lowest wins");
        run_case(13'h0080, "R7 wdog vector");

        // R4 suppression
        wr(8'h14, 16'h0003);
        run_case(13'h0001, "R4 code below 4");

        // R6 autovector explicit
        wr(8'h18, 16'h0094);
        run_case(13'h0010, "R6 autovector level 5");
        chk("R6 vector value", int'(cpu_vector), 29);

        // R9 byte store and zero-extended read
        wr(8'h17, 16'hABCD);
        rd(8'h17, d); chk("R9 ctrl readback", int'(d), 'h00CD);

        // Second configuration: mixed codes and vector sources
        wr(8'h44, 16'h0061); wr(8'h45, 16'h0062);
        for (int i = 1; i <= 13; i++) wr(8'(8'h13 + i), 16'((i * 37 + 5) & 'h9F));
        sweep("R3 R4 R5 R6 R7 mixed sweep");

        // Third configuration: all codes equal, alternating autovector, partial mask
        for (int i = 1; i <= 13; i++) wr(8'(8'h13 + i), (i % 2) ? 16'h0090 : 16'h0010);
        wr(8'h36, 16'h0924);
        sweep("R2 R3 R6 tie sweep");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule